// File: doc/BRIEF.md
# Masked Interrupt Event Controller

This block gathers five single-cycle event strobes (timer A underflow, timer B underflow, time-of-day alarm, serial transfer complete and an external edge input) into a sticky flag register. A mask register decides which of those flags may raise the one active-high interrupt line. When an enabled flag raises the line, a summary bit is recorded in bit 7 of the flag register.

Software reaches the block through a single register select. A write updates the mask with a set/clear protocol: data bit 7 chooses whether the ones in bits 4:0 set or clear the matching mask bits, and mask bits paired with a zero are left as they were. A read returns the flags together with the summary bit, then clears the flags and releases the line. An event that lands in the same cycle as such a read is kept as a flag, but it does not raise the line.

Top module: `irq_event_ctrl`

## Requirements
- R1: After synchronous reset, the flags, mask and summary are all zero, `irq` is low and `rd_data` is 0.
- R2: Each strobe on `ev_in` latches into the flag bit of the same index: 0 timer A, 1 timer B, 2 time-of-day alarm, 3 serial done, 4 edge input. A read places flags in `rd_data[4:0]`, the summary in bit 7 and zero in bits 6:5.
- R3: Flags are latched whether or not they are enabled in the mask. A flag that is masked off never raises `irq`.
- R4: A select write with `wr_data[7]`=1 sets every mask bit whose data bit in 4:0 is 1. With `wr_data[7]`=0 it clears them. Mask bits paired with a 0 keep their value.
- R5: An event that arrives while its mask bit is set and no read is under way drives `irq` high from the next clock edge onward. From then on a read returns bit 7 = 1.
- R6: A select read returns the flags and summary current in that cycle. At the following edge it clears the summary and every flag not struck again in that same cycle, so `irq` is low in the next cycle.
- R7: An event that coincides with a read is latched as a flag. It neither raises `irq` nor sets the summary bit, including in the cycles after the read, until a later event or mask write triggers it.
- R8: A set-mode mask write whose data enables a flag that is already pending drives `irq` high in the next cycle.
- R9: `rd_data` is 0 in every cycle without a select read. The mask itself is never returned on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 5 | One-cycle event strobes, one per source |
| reg_sel | input | 1 | Register select |
| rd_en | input | 1 | Read strobe (qualified by select) |
| wr_en | input | 1 | Write strobe (qualified by select) |
| wr_data | input | 8 | Mask write data: bit 7 picks set or clear, bits 4:0 pick the mask bits |
| rd_data | output | 8 | Flags and summary bit during a read, otherwise 0 |
| irq | output | 1 | Active-high interrupt line |

## Verification
Two functions can fall in the same cycle: the clear-on-read of the flag register and the arrival of a new enabled event. The bench drives a select read and an event strobe on the same clock. It then expects `irq` to stay low and the flag to come back without bit 7 on the next read. It also places a set-mode mask write on a cycle where a flag is already pending, and checks that the line rises one cycle later. A reference model runs alongside and checks `rd_data` and `irq` on every cycle.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int NUM_SRC  = 5;
    localparam int BUS_W    = 8;
    localparam int MODE_BIT = BUS_W - 1;
    localparam int SUM_BIT  = BUS_W - 1;
    localparam int PAD_W    = BUS_W - 1 - NUM_SRC;

    typedef enum logic [2:0] {
        SRC_TMR_A  = 3'd0,
        SRC_TMR_B  = 3'd1,
        SRC_ALARM  = 3'd2,
        SRC_SERIAL = 3'd3,
        SRC_EDGE   = 3'd4
    } src_idx_e;

    typedef struct packed {
        logic               rd;
        logic               wr;
        logic               set_mode;
        logic [NUM_SRC-1:0] bits;
    } bus_op_t;

    function automatic logic [NUM_SRC-1:0] mask_apply(
        input logic [NUM_SRC-1:0] cur,
        input logic               set_mode,
        input logic [NUM_SRC-1:0] bits
    );
        return set_mode ? (cur | bits) : (cur & ~bits);
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] ev,
    input  logic               clr,
    output logic [NUM_SRC-1:0] flg
);
    logic [NUM_SRC-1:0] flg_q;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    flg_q[i] <= 1'b0;
                else if (clr)
                    flg_q[i] <= ev[i];
                else
                    flg_q[i] <= flg_q[i] | ev[i];
            end
        end
    endgenerate

    assign flg = flg_q;

    // R3
    flag_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (|ev) |=> ((flg & $past(ev)) == $past(ev)));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (flg == $past(ev)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_op_t            op,
    output logic [NUM_SRC-1:0] msk
);
    logic [NUM_SRC-1:0] msk_q;

    always_ff @(posedge clk) begin
        if (rst)
            msk_q <= '0;
        else if (op.wr)
            msk_q <= mask_apply(msk_q, op.set_mode, op.bits);
    end

    assign msk = msk_q;

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (op.wr && op.set_mode) |=> ((msk & $past(op.bits)) == $past(op.bits)));

    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (op.wr && !op.set_mode) |=> ((msk & $past(op.bits)) == '0));

    // R4
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        op.wr |=> ((msk & ~$past(op.bits)) == ($past(msk) & ~$past(op.bits))));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_op_t            op,
    input  logic [NUM_SRC-1:0] ev,
    input  logic [NUM_SRC-1:0] flg,
    input  logic [NUM_SRC-1:0] msk,
    output logic               sum
);
    logic sum_q;
    logic ev_hit;
    logic wr_hit;

    always_comb begin
        ev_hit = |(ev & msk);
        wr_hit = op.wr && op.set_mode && (|(op.bits & (flg | ev)));
    end

    always_ff @(posedge clk) begin
        if (rst)
            sum_q <= 1'b0;
        else if (op.rd)
            sum_q <= 1'b0;
        else if (ev_hit || wr_hit)
            sum_q <= 1'b1;
    end

    assign sum = sum_q;

    // R7
    read_drops_sum_chk: assert property (@(posedge clk) disable iff (rst)
        op.rd |=> !sum);

    // R8
    enable_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (!op.rd && op.wr && op.set_mode && (|(op.bits & flg))) |=> sum);
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
    import irq_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] ev_in,
    input  logic               reg_sel,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [BUS_W-1:0]   wr_data,
    output logic [BUS_W-1:0]   rd_data,
    output logic               irq
);
    bus_op_t            op;
    logic [NUM_SRC-1:0] flg;
    logic [NUM_SRC-1:0] msk;
    logic               sum;

    always_comb begin
        op.rd       = reg_sel && rd_en;
        op.wr       = reg_sel && wr_en;
        op.set_mode = wr_data[MODE_BIT];
        op.bits     = wr_data[NUM_SRC-1:0];
    end

    irq_flag_bank u_flags (
        .clk (clk),
        .rst (rst),
        .ev  (ev_in),
        .clr (op.rd),
        .flg (flg)
    );

    irq_mask_reg u_mask (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .msk (msk)
    );

    irq_summary u_sum (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .ev  (ev_in),
        .flg (flg),
        .msk (msk),
        .sum (sum)
    );

    always_comb begin
        if (op.rd)
            rd_data = {sum, {PAD_W{1'b0}}, flg};
        else
            rd_data = '0;
    end

    assign irq = sum;

    // R5
    enabled_event_chk: assert property (@(posedge clk) disable iff (rst)
        (!op.rd && (|(ev_in & msk))) |=> irq);

    // R6
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        op.rd |=> !irq);

    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !op.rd |-> (rd_data == '0));

    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq && msk == '0 && !op.wr) |=> !irq);
endmodule

// File: tb/sim_irq_event_ctrl.sv
module sim_irq_event_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] ev_in = '0;
    logic       reg_sel = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int m_flg = 0;
    int m_msk = 0;
    int m_sum = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_event_ctrl u0 (
        .clk(clk), .rst(rst), .ev_in(ev_in), .reg_sel(reg_sel),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic cmp(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input int ev, input bit rd, input bit wr, input int wd, input string tag);
        int exp_rd;
        int trig;
        @(negedge clk);
        ev_in   = ev[4:0];
        reg_sel = rd | wr;
        rd_en   = rd;
        wr_en   = wr;
        wr_data = wd[7:0];
        #2;
        exp_rd = rd ? ((m_sum << 7) | m_flg) : 0;
        cmp(int'(rd_data), exp_rd, tag, "rd_data");
        cmp(int'(irq), m_sum, tag, "irq");
        @(posedge clk);
        trig = ((ev & m_msk) != 0) ||
               (wr && (wd & 8'h80) != 0 && ((wd & 8'h1f) & (m_flg | ev)) != 0);
        if (rd) begin
            m_flg = ev;
            m_sum = 0;
        end else begin
            m_flg = m_flg | ev;
            if (trig) m_sum = 1;
        end
        if (wr) begin
            if ((wd & 8'h80) != 0) m_msk = m_msk | (wd & 8'h1f);
            else m_msk = m_msk & ~(wd & 8'h1f) & 8'h1f;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        step(0, 0, 0, 0, "R1");
        step(0, 1, 0, 0, "R1");
        // R3 masked event latches, no irq
        step(5'h01, 0, 0, 0, "R3");
        step(0, 0, 0, 0, "R3");
        // R2 read shows timer A flag at bit 0
        step(0, 1, 0, 0, "R2");
        step(0, 0, 0, 0, "R6");
        // R4 enable all sources
        step(0, 0, 1, 8'h9f, "R4");
        for (int i = 0; i < 5; i++) begin
            step(1 << i, 0, 0, 0, "R2");
            step(0, 0, 0, 0, "R5");
            step(0, 1, 0, 0, "R5");
            step(0, 0, 0, 0, "R6");
        end
        // R4 clear timer A and B, keep others
        step(0, 0, 1, 8'h03, "R4");
        step(5'h01, 0, 0, 0, "R4");
        step(5'h02, 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R4");
        step(5'h04, 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R4");
        step(0, 1, 0, 0, "R6");
        step(0, 0, 0, 0, "R6");
        // R8 enable an already pending flag
        step(0, 0, 1, 8'h1f, "R8");
        step(5'h10, 0, 0, 0, "R8");
        step(0, 0, 0, 0, "R8");
        step(0, 0, 1, 8'h90, "R8");
        step(0, 0, 0, 0, "R8");
        step(0, 1, 0, 0, "R8");
        // R7 event coincides with read
        step(0, 0, 1, 8'h9f, "R7");
        step(5'h02, 1, 0, 0, "R7");
        step(0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, "R7");
        step(0, 1, 0, 0, "R7");
        step(0, 0, 0, 0, "R7");
        // R6 read with flags pending and a fresh enabled event after
        step(5'h08, 0, 0, 0, "R6");
        step(5'h01, 1, 0, 0, "R6");
        step(5'h04, 0, 0, 0, "R6");
        step(0, 1, 0, 0, "R6");
        // R9 write alone returns zero
        step(0, 0, 1, 8'h80, "R9");
        step(5'h1f, 0, 0, 0, "R9");
        step(0, 1, 0, 0, "R9");
        step(0, 0, 0, 0, "R9");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule